// File: doc/BRIEF.md
# Serial Word EEPROM Slave Model

This block is a synthesizable stand-in for a small serial EEPROM of 16-bit words. It sits behind a select line, a serial clock and a serial data input, and answers on one serial data output. The block runs on a fast system clock. The three serial inputs are synchronised into that clock domain, and the block acts on each detected rising edge of the serial clock. A frame starts with a 1 bit. A two-bit command code follows, then a word address, then sixteen data bits for the commands that carry data.

The commands are: read one word, write one word, erase one word, erase every word, write one value to every word, enable programming and disable programming. The address width is a parameter. The default of 6 gives 64 words, and 8 gives the larger variant with 256 words. Programming time, busy signalling and data retention are not modelled. A write or erase takes effect in the system-clock cycle after the frame completes.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `dout` is 0, every word reads 16'hFFFF and programming is disabled.
- R2: Bits are sampled only on rising edges of `sk` while `cs` is high. While the block waits for a frame, 0 bits are skipped and the first 1 bit is the start bit.
- R3: Code 2'b10 reads a word. The edge that captures the last address bit drives `dout` to 0. Each of the next 16 rising edges launches one bit of the word, starting with bit 15. The edge after bit 0 returns `dout` to 0.
- R4: Code 2'b01 followed by 16 data bits (bit 15 first) stores the data at the address, if programming is enabled.
- R5: Code 2'b11 sets the addressed word to 16'hFFFF, if programming is enabled. All other words keep their values.
- R6: With code 2'b00, the two top address bits select a sub-command and the lower address bits are ignored. 2'b11 enables programming and 2'b00 disables it.
- R7: Code 2'b00 with sub-command 2'b10 sets every word to 16'hFFFF, if programming is enabled.
- R8: Code 2'b00 with sub-command 2'b01, followed by 16 data bits, writes that value to every word, if programming is enabled.
- R9: While programming is disabled, write, erase, erase-all and write-all leave the memory unchanged.
- R10: Driving `cs` low at any point aborts the frame. A partly shifted write is discarded, `dout` goes to 0, and the next frame is decoded from its start bit.
- R11: `dout` is 0 whenever the block is not in the data-out phase of a read.
- R12: The `ADDR_W` parameter sets the address width and the word count (2**ADDR_W). Every address from 0 to 2**ADDR_W-1 holds its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high; going low aborts a frame |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data into the block |
| dout | output | 1 | Serial read data; 0 outside the read data phase |

## Verification
Some rules can be checked on every cycle, and the checker does so. It checks that the decoder advances only on a serial-clock edge, that a dropped select returns it to idle, and that `dout` stays low outside the read phase and on the dummy bit. It also checks that a storage write happens only at the end of a frame while programming is enabled. The bench scenarios are needed for the stored contents: the bit order of read data, full-array sweeps after single writes, write-all and erase-all, whether the lower address bits are ignored in sub-commands, and whether an aborted write left a word unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } mw_state_e;

  localparam logic [1:0] CODE_EXT   = 2'b00;
  localparam logic [1:0] CODE_WRITE = 2'b01;
  localparam logic [1:0] CODE_READ  = 2'b10;
  localparam logic [1:0] CODE_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic rst_n_o,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o
);

  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic [SYNC_DEPTH-1:0] cs_pipe;
  logic [SYNC_DEPTH-1:0] di_pipe;
  logic [SYNC_DEPTH:0]   sk_pipe;

  // Reset asserts at once and releases after SYNC_DEPTH clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end

  assign rst_n_o = rst_pipe[SYNC_DEPTH-1];

  // cs and di go through the same depth as sk, so they stay aligned with the edge pulse.
  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) begin
      cs_pipe <= '0;
      di_pipe <= '0;
      sk_pipe <= '0;
    end else begin
      cs_pipe <= {cs_pipe[SYNC_DEPTH-2:0], cs_i};
      di_pipe <= {di_pipe[SYNC_DEPTH-2:0], di_i};
      sk_pipe <= {sk_pipe[SYNC_DEPTH-1:0], sk_i};
    end
  end

  assign cs_o      = cs_pipe[SYNC_DEPTH-1];
  assign di_o      = di_pipe[SYNC_DEPTH-1];
  assign sk_rise_o = sk_pipe[SYNC_DEPTH-1] & ~sk_pipe[SYNC_DEPTH];

endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              dout,
  output mw_state_e         state_o,
  output logic              prog_en_o
);

  localparam int CNT_MAX = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] READ_END  = CNT_W'(WORD_W);

  mw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-2:0] data_q, data_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              dout_q, dout_d;
  logic              prog_q, prog_d;
  logic              wen_q, wen_c;
  logic              wall_q, wall_c;
  logic [ADDR_W-1:0] waddr_q, waddr_c;
  logic [WORD_W-1:0] wdata_q, wdata_c;

  logic [ADDR_W-1:0] addr_full;
  logic [WORD_W-1:0] data_full;
  logic [1:0]        sub_sel;

  assign addr_full = {addr_q[ADDR_W-2:0], di};
  assign data_full = {data_q, di};
  assign sub_sel   = addr_full[ADDR_W-1 -: 2];
  assign rd_addr   = addr_full;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    code_d  = code_q;
    addr_d  = addr_q;
    data_d  = data_q;
    out_d   = out_q;
    dout_d  = dout_q;
    prog_d  = prog_q;
    wen_c   = 1'b0;
    wall_c  = 1'b0;
    waddr_c = addr_q;
    wdata_c = data_full;

    if (!cs) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      dout_d  = 1'b0;
    end else if (sk_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (di) state_d = ST_OP;
        end
        ST_OP: begin
          code_d = {code_q[0], di};
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_d = addr_full;
          if (cnt_q == ADDR_LAST) begin
            cnt_d   = '0;
            state_d = ST_DONE;
            unique case (code_q)
              CODE_READ: begin
                state_d = ST_READ;
                out_d   = rd_word;
                dout_d  = 1'b0;
              end
              CODE_WRITE: state_d = ST_DATA;
              CODE_ERASE: begin
                wen_c   = prog_q;
                waddr_c = addr_full;
                wdata_c = '1;
              end
              default: begin
                unique case (sub_sel)
                  SUB_UNLOCK: prog_d = 1'b1;
                  SUB_LOCK:   prog_d = 1'b0;
                  SUB_WIPE: begin
                    wen_c   = prog_q;
                    wall_c  = 1'b1;
                    wdata_c = '1;
                  end
                  default: state_d = ST_DATA;
                endcase
              end
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_d = data_full[WORD_W-2:0];
          if (cnt_q == DATA_LAST) begin
            state_d = ST_DONE;
            cnt_d   = '0;
            wen_c   = prog_q;
            wall_c  = (code_q == CODE_EXT);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_READ: begin
          if (cnt_q == READ_END) begin
            dout_d  = 1'b0;
            state_d = ST_DONE;
          end else begin
            dout_d = out_q[WORD_W-1];
            out_d  = {out_q[WORD_W-2:0], 1'b0};
            cnt_d  = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      out_q   <= '0;
      dout_q  <= 1'b0;
      prog_q  <= 1'b0;
      wen_q   <= 1'b0;
      wall_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      out_q   <= out_d;
      dout_q  <= dout_d;
      prog_q  <= prog_d;
      wen_q   <= wen_c;
      wall_q  <= wall_c;
      waddr_q <= waddr_c;
      wdata_q <= wdata_c;
    end
  end

  assign wr_en     = wen_q;
  assign wr_all    = wall_q;
  assign wr_addr   = waddr_q;
  assign wr_data   = wdata_q;
  assign dout      = dout_q;
  assign state_o   = state_q;
  assign prog_en_o = prog_q;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][WORD_W-1:0] mem_q;
  logic [DEPTH-1:0]             sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel[i] = wr_en & (wr_all | (wr_addr == ADDR_W'(i)));
  end

  // Reset fills the array with the erased value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel[i]) mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int WORD_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);

  logic              rst_n_s;
  logic              cs_s;
  logic              di_s;
  logic              sk_rise;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              wr_en;
  logic              wr_all;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  mw_state_e         state;
  logic              prog_en;

  mw_in_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs),
    .sk_i      (sk),
    .di_i      (di),
    .rst_n_o   (rst_n_s),
    .cs_o      (cs_s),
    .di_o      (di_s),
    .sk_rise_o (sk_rise)
  );

  mw_cmd_decode #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs        (cs_s),
    .di        (di_s),
    .sk_rise   (sk_rise),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_all    (wr_all),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dout      (dout),
    .state_o   (state),
    .prog_en_o (prog_en)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input logic      sk_rise,
  input logic      dout,
  input mw_state_e state,
  input logic      prog_en,
  input logic      wr_en
);

  AST_NO_EDGE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !sk_rise) |=> $stable(state)); // R2

  AST_READ_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_READ) |-> !dout); // R3

  AST_WRITE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_DONE)); // R4

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> prog_en); // R9

  AST_DESELECT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (state == ST_IDLE)); // R10

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ) |-> !dout); // R11

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .cs_s    (cs_s),
  .sk_rise (sk_rise),
  .dout    (dout),
  .state   (state),
  .prog_en (prog_en),
  .wr_en   (wr_en)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cs;
  logic sk;
  logic di;
  logic dout;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [15:0] model [DEPTH];
  bit          prog_m;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .sk    (sk),
    .di    (di),
    .dout  (dout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sk = 1'b0;
    di = b;
    wait_clk(HALF);
    sk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic begin_frame();
    sk = 1'b0;
    cs = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic end_frame();
    sk = 1'b0;
    wait_clk(HALF);
    cs = 1'b0;
    di = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_head(input logic [1:0] code, input int addr);
    send_bit(1'b1);
    send_bit(code[1]);
    send_bit(code[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(addr[i]);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  // Frame with optional data; the model applies the requirement rules.
  task automatic command(input logic [1:0] code, input int addr, input logic [15:0] w);
    logic [1:0] sub;
    sub = 2'(addr >> (AW - 2));
    begin_frame();
    send_head(code, addr);
    if (code == 2'b01 || (code == 2'b00 && sub == 2'b01)) send_word(w);
    end_frame();
    if (code == 2'b01 && prog_m) model[addr] = w;
    if (code == 2'b11 && prog_m) model[addr] = 16'hFFFF;
    if (code == 2'b00) begin
      case (sub)
        2'b11: prog_m = 1'b1;
        2'b00: prog_m = 1'b0;
        2'b10: if (prog_m) for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
        default: if (prog_m) for (int a = 0; a < DEPTH; a++) model[a] = w;
      endcase
    end
  endtask

  task automatic read_word(input int addr, input int lead_zeros, input string req);
    logic [15:0] got;
    begin_frame();
    for (int z = 0; z < lead_zeros; z++) send_bit(1'b0);
    send_head(2'b10, addr);
    check(dout == 1'b0, "R3", "dummy bit before data", 32'(dout), 32'h0);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0);
      got[i] = dout;
    end
    check(got == model[addr], req, $sformatf("word at %0d", addr), 32'(got), 32'(model[addr]));
    send_bit(1'b0);
    check(dout == 1'b0, "R11", "dout after last read bit", 32'(dout), 32'h0);
    end_frame();
  endtask

  function automatic logic [15:0] pattern(input int a);
    return 16'(a * 839) ^ 16'hB00F;
  endfunction

  function automatic int ext_addr(input logic [1:0] sub, input int low);
    return (int'(sub) << (AW - 2)) | (low & ((1 << (AW - 2)) - 1));
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=running expected=complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    prog_m = 1'b0;
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    wait_clk(5);
    check(dout == 1'b0, "R1", "dout in reset", 32'(dout), 32'h0);
    rst_n = 1'b1;
    wait_clk(5);
    check(dout == 1'b0, "R1", "dout after reset", 32'(dout), 32'h0);

    // R1: erased contents after reset.
    read_word(0, 0, "R1");
    read_word(DEPTH - 1, 0, "R1");

    // R9: programming disabled after reset.
    command(2'b01, 5, 16'h1234);
    read_word(5, 0, "R9");
    command(2'b00, ext_addr(2'b01, 3), 16'h0F0F);
    read_word(9, 0, "R9");

    // R6: enable with lower address bits set to arbitrary values.
    command(2'b00, ext_addr(2'b11, 6), 16'h0);

    // R4, R12: write a distinct value to every address, then sweep.
    for (int a = 0; a < DEPTH; a++) command(2'b01, a, pattern(a));
    check(dout == 1'b0, "R11", "dout after write frame", 32'(dout), 32'h0);
    for (int a = 0; a < DEPTH; a++) read_word(a, 0, "R12");

    // R5: erase one word, neighbour untouched.
    command(2'b11, 10, 16'h0);
    read_word(10, 0, "R5");
    read_word(11, 0, "R5");

    // R2: leading zeros before the start bit are skipped.
    read_word(33, 3, "R2");

    // R10: aborted write leaves the word unchanged.
    begin_frame();
    send_head(2'b01, 20);
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    end_frame();
    read_word(20, 0, "R10");

    // R10: aborted read returns dout low and the next frame decodes cleanly.
    begin_frame();
    send_head(2'b10, 7);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    sk = 1'b0;
    cs = 1'b0;
    wait_clk(HALF);
    check(dout == 1'b0, "R10", "dout after deselect mid-read", 32'(dout), 32'h0);
    wait_clk(HALF);
    read_word(7, 0, "R10");

    // R6, R9: disable, then programming commands change nothing.
    command(2'b00, ext_addr(2'b00, 5), 16'h0);
    command(2'b01, 3, 16'hAAAA);
    command(2'b11, 4, 16'h0);
    command(2'b00, ext_addr(2'b10, 0), 16'h0);
    read_word(3, 0, "R9");
    read_word(4, 0, "R9");
    read_word(50, 0, "R6");

    // R8: write-all after re-enabling.
    command(2'b00, ext_addr(2'b11, 0), 16'h0);
    command(2'b00, ext_addr(2'b01, 9), 16'hC3A5);
    for (int a = 0; a < DEPTH; a++) read_word(a, 0, "R8");

    // R7: erase-all.
    command(2'b00, ext_addr(2'b10, 12), 16'h0);
    for (int a = 0; a < DEPTH; a++) read_word(a, 0, "R7");

    finished = 1'b1;
    finish_run();
  end

endmodule